// File: doc/BRIEF.md
# Channel Event Queue Controller

This block gathers exception events raised by the channels of a multichannel serial controller. It stores them in a small circular table and signals the host. A producer pushes a channel number with an event code. The block writes each push into the next table slot, marks the slot valid and moves on around the table. If the next slot is still waiting for the host, the block does not overwrite it. The new event is dropped and an overflow flag is raised. Two single-cycle pulses report a global transmit underrun and a global receive overrun. Each pulse sets its own flag and freezes only its own direction.

The host reads and clears flags in an 8-bit event register using write-one-to-clear. It enables interrupt sources in a mask register. It reads table entries by index and releases a serviced entry with a valid-clear strobe. After the host reinitialises the channels, it restarts a frozen direction with that direction's resume strobe.

Top module: `evq_ctrl`

## Requirements
- R1: After reset the event register, the mask register, all entry valid bits and both halt outputs are 0, and the write pointer is at entry 0. The register bits are numbered big-endian, so bit 0 is the physical MSB. Bits 0..3 are physical bits [7:4] and always read 0 in both registers. The flags sit at physical bit 3 (overflow, 0x08), bit 2 (global interrupt, 0x04), bit 1 (transmit underrun, 0x02) and bit 0 (receive overrun, 0x01).
- R2: An accepted push stores the channel number and event code at the write-pointer slot and sets that slot's valid bit, visible on the entry read port one cycle later. The pointer then advances by one and wraps from DEPTH-1 to 0.
- R3: A push whose target slot is still valid is dropped. The overflow flag is set, the pending entry keeps its contents and the write pointer does not move.
- R4: Every accepted push sets the global interrupt flag.
- R5: A register write with address 0 clears each event flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R6: When the host clears a flag and the hardware sets the same flag in the same cycle, the flag stays set.
- R7: irq is 1 exactly when some event flag is 1 and its mask bit, at the same position and written with address 1, is 1.
- R8: A transmit underrun pulse sets the underrun flag and raises tx_halt. rx_halt is unaffected.
- R9: A receive overrun pulse sets the overrun flag and raises rx_halt. tx_halt is unaffected.
- R10: A halt stays asserted until its own resume strobe. The other direction's resume, flag clears and pushes do not release it. Resuming does not clear the flag. If a resume and a new pulse of the same direction arrive together, the halt stays asserted.
- R11: A valid-clear strobe clears the valid bit of the indexed entry, which lets the writer reuse that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer pushes an event this cycle |
| push_chan | input | CH_W | Channel number of the pushed event |
| push_code | input | CODE_W | Event code of the pushed event |
| tx_underrun | input | 1 | Global transmit underrun pulse |
| rx_overrun | input | 1 | Global receive overrun pulse |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 1 | 0 selects the event register, 1 the mask register |
| reg_wdata | input | 8 | Host write data |
| evt_flags | output | 8 | Event register contents |
| evt_mask | output | 8 | Mask register contents |
| rd_idx | input | $clog2(DEPTH) | Table entry to read |
| rd_valid | output | 1 | Valid bit of the read entry |
| rd_chan | output | CH_W | Channel number of the read entry |
| rd_code | output | CODE_W | Event code of the read entry |
| clr_valid | input | 1 | Valid-clear strobe |
| clr_idx | input | $clog2(DEPTH) | Entry whose valid bit is cleared |
| tx_resume | input | 1 | Host restarts transmit |
| rx_resume | input | 1 | Host restarts receive |
| irq | output | 1 | Interrupt request |
| tx_halt | output | 1 | Transmit frozen on all channels |
| rx_halt | output | 1 | Receive frozen |

## Verification
The bench builds the block with its defaults: a table of 16 entries, 5-bit channel numbers and 4-bit codes. The small table lets a directed sequence fill every slot, wrap the pointer and reach the overflow drop within a few dozen cycles. The 5-bit channel width lets the extreme channel value 31 and code 15 be stored and read back. The same-cycle collisions are forced on purpose: a clear against a set, and a resume against a fresh pulse.

// File: rtl/evq_ctrl.sv
module evq_ctrl #(
  parameter int DEPTH  = 16,
  parameter int CH_W   = 5,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid,
  input  logic [CH_W-1:0]          push_chan,
  input  logic [CODE_W-1:0]        push_code,
  input  logic                     tx_underrun,
  input  logic                     rx_overrun,
  input  logic                     reg_wr,
  input  logic                     reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               evt_flags,
  output logic [7:0]               evt_mask,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     rd_valid,
  output logic [CH_W-1:0]          rd_chan,
  output logic [CODE_W-1:0]        rd_code,
  input  logic                     clr_valid,
  input  logic [$clog2(DEPTH)-1:0] clr_idx,
  input  logic                     tx_resume,
  input  logic                     rx_resume,
  output logic                     irq,
  output logic                     tx_halt,
  output logic                     rx_halt
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [7:0] LIVE = 8'h0F;

  logic [CH_W-1:0]   chan_q [DEPTH];
  logic [CODE_W-1:0] code_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [PW-1:0]     wr_ptr;
  logic [3:0]        flags_q;
  logic [3:0]        mask_q;

  wire slot_busy = vld_q[wr_ptr];
  wire accept    = push_valid && !slot_busy;
  wire drop      = push_valid && slot_busy;

  wire [3:0] hw_set = {drop, accept, tx_underrun, rx_overrun};
  wire [3:0] sw_clr = (reg_wr && !reg_addr) ? reg_wdata[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      vld_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (accept && wr_ptr == PW'(i))
          vld_q[i] <= 1'b1;
        else if (clr_valid && clr_idx == PW'(i))
          vld_q[i] <= 1'b0;
      end
      if (accept)
        wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      chan_q[wr_ptr] <= push_chan;
      code_q[wr_ptr] <= push_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      tx_halt <= 1'b0;
      rx_halt <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~sw_clr) | hw_set;
      if (reg_wr && reg_addr)
        mask_q <= reg_wdata[3:0];
      if (tx_underrun)
        tx_halt <= 1'b1;
      else if (tx_resume)
        tx_halt <= 1'b0;
      if (rx_overrun)
        rx_halt <= 1'b1;
      else if (rx_resume)
        rx_halt <= 1'b0;
    end
  end

  assign evt_flags = {4'b0, flags_q} & LIVE;
  assign evt_mask  = {4'b0, mask_q} & LIVE;
  assign irq       = |(flags_q & mask_q);
  assign rd_valid  = vld_q[rd_idx];
  assign rd_chan   = chan_q[rd_idx];
  assign rd_code   = code_q[rd_idx];
endmodule

// File: rtl/evq_ctrl_chk.sv
module evq_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic [DEPTH-1:0] vld_q,
  input logic [PW-1:0]    wr_ptr,
  input logic [7:0]       evt_flags,
  input logic [7:0]       evt_mask,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [7:0]       reg_wdata,
  input logic             tx_underrun,
  input logic             tx_resume,
  input logic             tx_halt,
  input logic             rx_overrun,
  input logic             rx_resume,
  input logic             rx_halt
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flags[7:4] == 4'b0 && evt_mask[7:4] == 4'b0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && vld_q[wr_ptr] |=> evt_flags[3] && $stable(wr_ptr));

  assert_gint_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !vld_q[wr_ptr] |=> evt_flags[2] && vld_q[$past(wr_ptr)]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !vld_q[wr_ptr] && reg_wr && !reg_addr && reg_wdata[2] |=> evt_flags[2]);

  assert_tx_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> tx_halt && evt_flags[1]);

  assert_rx_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_halt && evt_flags[0]);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halt && !tx_resume |=> tx_halt);

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_halt && !rx_resume |=> rx_halt);
endmodule

bind evq_ctrl evq_ctrl_chk #(.DEPTH(DEPTH), .PW($clog2(DEPTH))) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .vld_q(vld_q),
  .wr_ptr(wr_ptr), .evt_flags(evt_flags), .evt_mask(evt_mask),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .tx_underrun(tx_underrun), .tx_resume(tx_resume), .tx_halt(tx_halt),
  .rx_overrun(rx_overrun), .rx_resume(rx_resume), .rx_halt(rx_halt)
);

// File: tb/evq_ctrl_bench.sv
module evq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, tx_underrun = 0, rx_overrun = 0;
  logic [4:0] push_chan = 0;
  logic [3:0] push_code = 0;
  logic reg_wr = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [PW-1:0] rd_idx = 0, clr_idx = 0;
  logic clr_valid = 0, tx_resume = 0, rx_resume = 0;
  logic [7:0] evt_flags, evt_mask;
  logic rd_valid, irq, tx_halt, rx_halt;
  logic [4:0] rd_chan;
  logic [3:0] rd_code;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_ctrl u_evq_ctrl (
    .clk, .rst_n, .push_valid, .push_chan, .push_code, .tx_underrun, .rx_overrun,
    .reg_wr, .reg_addr, .reg_wdata, .evt_flags, .evt_mask, .rd_idx, .rd_valid,
    .rd_chan, .rd_code, .clr_valid, .clr_idx, .tx_resume, .rx_resume, .irq,
    .tx_halt, .rx_halt);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    push_valid = 0; reg_wr = 0; clr_valid = 0;
    tx_underrun = 0; rx_overrun = 0; tx_resume = 0; rx_resume = 0;
  endtask

  task automatic push(int ch, int code);
    push_valid = 1; push_chan = 5'(ch); push_code = 4'(code);
    tick();
  endtask

  task automatic wreg(bit addr, int data);
    reg_wr = 1; reg_addr = addr; reg_wdata = 8'(data);
    tick();
  endtask

  task automatic entry(string req, int idx, int v, int ch, int code);
    rd_idx = PW'(idx);
    #1;
    check(req, rd_valid, v);
    if (v) begin
      check(req, rd_chan, ch);
      check(req, rd_code, code);
    end
  endtask

  task automatic t_reset();
    check("R1 flags", evt_flags, 0);
    check("R1 mask", evt_mask, 0);
    check("R1 irq", irq, 0);
    check("R1 tx_halt", tx_halt, 0);
    check("R1 rx_halt", rx_halt, 0);
    entry("R1 entry0", 0, 0, 0, 0);
    wreg(1'b1, 8'hFF);
    check("R1 mask reserved", evt_mask, 8'h0F);
    wreg(1'b1, 8'h00);
  endtask

  task automatic t_push_and_clear();
    push(5, 3);
    entry("R2 entry0", 0, 1, 5, 3);
    check("R4 gint", evt_flags, 8'h04);
    push(31, 15);
    entry("R2 entry1", 1, 1, 31, 15);
    wreg(1'b0, 8'hF0);
    check("R5 zero/reserved write", evt_flags, 8'h04);
    wreg(1'b0, 8'h04);
    check("R5 w1c", evt_flags, 8'h00);
    check("R7 no flag", irq, 0);
    wreg(1'b1, 8'h04);
    check("R7 masked in, no flag", irq, 0);
    push(7, 1);
    check("R7 irq", irq, 1);
    wreg(1'b1, 8'h08);
    check("R7 masked out", irq, 0);
    wreg(1'b0, 8'h04);
  endtask

  task automatic t_overflow();
    for (int i = 3; i < DEPTH; i++) push(i, i % 16);
    check("R3 no overflow while free", evt_flags[3], 0);
    entry("R2 last slot", DEPTH-1, 1, DEPTH-1, (DEPTH-1) % 16);
    push(9, 9);
    check("R3 overflow flag", evt_flags[3], 1);
    entry("R3 entry0 kept", 0, 1, 5, 3);
    check("R7 overflow irq", irq, 1);
    clr_valid = 1; clr_idx = 0;
    tick();
    entry("R11 cleared", 0, 0, 0, 0);
    push(9, 7);
    entry("R11 reuse wrap R2", 0, 1, 9, 7);
    wreg(1'b0, 8'h0F);
    push(12, 12);
    check("R3 pointer held at 1", evt_flags, 8'h08);
    entry("R3 entry1 kept", 1, 1, 31, 15);
    for (int i = 0; i < DEPTH; i++) begin
      clr_valid = 1; clr_idx = PW'(i);
      tick();
    end
    wreg(1'b0, 8'h0F);
    check("R5 all cleared", evt_flags, 0);
  endtask

  task automatic t_set_wins();
    push_valid = 1; push_chan = 5'd2; push_code = 4'd2;
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'h04;
    tick();
    check("R6 set wins", evt_flags[2], 1);
    entry("R2 after wrap at slot1", 1, 1, 2, 2);
    wreg(1'b0, 8'h0F);
  endtask

  task automatic t_tx();
    tx_underrun = 1;
    tick();
    check("R8 flag", evt_flags, 8'h02);
    check("R8 tx_halt", tx_halt, 1);
    check("R8 rx untouched", rx_halt, 0);
    rx_resume = 1; tick();
    wreg(1'b0, 8'h02);
    push(1, 1);
    check("R10 other resume/clear/push", tx_halt, 1);
    tx_resume = 1; tick();
    check("R10 tx released", tx_halt, 0);
    tx_underrun = 1; tick();
    tx_underrun = 1; tx_resume = 1; tick();
    check("R10 pulse beats resume", tx_halt, 1);
    tx_resume = 1; tick();
    check("R10 flag kept after resume", evt_flags[1], 1);
    wreg(1'b0, 8'h0F);
  endtask

  task automatic t_rx();
    rx_overrun = 1;
    tick();
    check("R9 flag", evt_flags, 8'h01);
    check("R9 rx_halt", rx_halt, 1);
    check("R9 tx untouched", tx_halt, 0);
    tx_resume = 1; tick();
    check("R10 rx held", rx_halt, 1);
    wreg(1'b1, 8'h01);
    check("R7 overrun irq", irq, 1);
    rx_resume = 1; tick();
    check("R10 rx released", rx_halt, 0);
    check("R10 rx flag kept", evt_flags, 8'h01);
    wreg(1'b0, 8'h01);
    check("R7 irq drops", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_push_and_clear();
        t_overflow();
        t_set_wins();
        t_tx();
        t_rx();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule